// File: doc/BRIEF.md
# Preloaded Timer Time Base

This block is a counting time base for a larger timer. A programmable prescaler slows the input clock into count ticks. A counter steps on each tick between zero and a period value, either upward, downward or alternating. Each time the counter turns around it raises an update event. A repetition counter thins those events into a slower update interrupt request.

The prescaler divisor and the period are written into preload copies through a small write port. They become active only when an update event occurs, so software can prepare the next period without disturbing the one in progress. A software update request forces that transfer at once and restarts the count. The count value, the update event, the interrupt request and the current direction are all visible at the ports.

The direction is held by a two-state machine, ST_RISE and ST_FALL. A clear by software update moves it to ST_FALL in down mode and to ST_RISE otherwise. In center mode it takes the turn RISE→FALL at the top turn and FALL→RISE at the bottom turn. In the edge modes it follows the mode: RISE→FALL when down mode is selected and FALL→RISE when up mode is selected.

Top module: `tmr_timebase`

## Requirements
- R1: After reset the count is 0, the direction output is 0, no event or interrupt is raised, the prescaler divisor preload is 0 (tick every cycle), the period is all ones and the repetition preload is 0.
- R2: A write with wr_en high stores wr_data into a preload copy selected by wr_sel: 0 the prescaler divisor minus one, 1 the period, 2 the repetition count (low 8 bits); code 3 changes nothing.
- R3: While cnt_en is high the prescaler produces one count tick every (divisor preload value + 1) cycles, using the active divisor.
- R4: In up mode (mode 00) the counter increments per tick; on the tick at which it equals the active period it raises the update event and returns to 0.
- R5: In down mode (mode 01) the counter decrements per tick; on the tick at which it is 0 it raises the update event and reloads the period.
- R6: In center mode (mode 10 or 11) the counter climbs to the period and falls back to 0, raising the update event at each turn, and dir_down flips at each turn.
- R7: In the edge modes the update event repeats every (period+1)·(divisor+1) cycles; in center mode every period·(divisor+1) cycles.
- R8: Writes to the preload copies do not alter the period in progress; the active divisor and period take the preload values only at an update event.
- R9: A software update request raises update_evt in the same cycle, loads the active settings from the preloads, clears the prescaler, sets the count to 0 (to the period in down mode) and reloads the repetition counter.
- R10: update_irq is raised only with a counter-driven update event, and only when the repetition counter is 0, which then reloads from its preload; with preload N the interrupt fires on every (N+1)-th event.
- R11: While cnt_en is low the count, prescaler and repetition counter hold, and no counter-driven event is raised.
- R12: dir_down is 1 whenever the counter is counting downward: always in down mode and in the falling half of center mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_en | input | 1 | Count enable |
| mode | input | 2 | 00 up, 01 down, 10/11 center |
| wr_en | input | 1 | Preload write strobe |
| wr_sel | input | 2 | Preload select: 0 divisor, 1 period, 2 repetition |
| wr_data | input | 16 | Preload write data |
| sw_update | input | 1 | Software update request |
| count_value | output | 16 | Live counter value |
| update_evt | output | 1 | Update event pulse |
| update_irq | output | 1 | Update interrupt request pulse |
| dir_down | output | 1 | Current count direction, 1 = down |

## Verification
A wrong prescaler or period shadow shows as a wrong spacing between update events, but only from the first update after the fault, so the bench measures whole intervals rather than single cycles. A direction state that is out of step shows within one tick as a count moving the wrong way or as dir_down failing to flip at a turn. A wrong repetition count appears only once per interrupt group, so several consecutive events are watched to catch an interrupt that lands on the wrong one.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [1:0] {
        MODE_UP    = 2'b00,
        MODE_DOWN  = 2'b01,
        MODE_CTR   = 2'b10,
        MODE_CTR_B = 2'b11
    } tmr_mode_e;

    typedef enum logic {
        ST_RISE = 1'b0,
        ST_FALL = 1'b1
    } dir_state_e;

    typedef enum logic [1:0] {
        SEL_DIV  = 2'b00,
        SEL_PER  = 2'b01,
        SEL_REP  = 2'b10,
        SEL_NONE = 2'b11
    } wr_sel_e;

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int PSC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             clr,
    input  logic [PSC_W-1:0] div_act,
    output logic             tick
);
    logic [PSC_W-1:0] pcnt_q;
    logic             at_last;

    assign at_last = (pcnt_q >= div_act);
    assign tick    = en && !clr && at_last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pcnt_q <= '0;
        end else if (clr) begin
            pcnt_q <= '0;
        end else if (en) begin
            pcnt_q <= at_last ? '0 : pcnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             clr,
    input  logic [1:0]       mode,
    input  logic [CNT_W-1:0] period_act,
    input  logic [CNT_W-1:0] period_next,
    output logic [CNT_W-1:0] count,
    output logic             wrap,
    output logic             dir_down
);
    dir_state_e       state_q, state_d;
    logic [CNT_W-1:0] count_q, count_d;
    logic             going_down;
    logic             at_end;
    logic             ctr_mode;

    assign ctr_mode   = mode[1];
    assign going_down = (mode == MODE_DOWN) || (ctr_mode && state_q == ST_FALL);
    assign at_end     = going_down ? (count_q == '0) : (count_q >= period_act);
    assign wrap       = tick && !clr && at_end;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RISE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (clr) begin
            state_d = (mode == MODE_DOWN) ? ST_FALL : ST_RISE;
        end else begin
            unique case (state_q)
                ST_RISE: begin
                    if (mode == MODE_DOWN)      state_d = ST_FALL;
                    else if (ctr_mode && wrap)  state_d = ST_FALL;
                end
                ST_FALL: begin
                    if (mode == MODE_UP)        state_d = ST_RISE;
                    else if (ctr_mode && wrap)  state_d = ST_RISE;
                end
            endcase
        end
    end

    // count value
    always_comb begin
        count_d = count_q;
        if (clr) begin
            count_d = (mode == MODE_DOWN) ? period_next : '0;
        end else if (tick) begin
            if (!at_end) begin
                count_d = going_down ? count_q - 1'b1 : count_q + 1'b1;
            end else if (ctr_mode) begin
                if (going_down) count_d = (period_next == '0) ? '0 : CNT_W'(1);
                else            count_d = (period_act == '0) ? '0 : period_act - 1'b1;
            end else begin
                count_d = going_down ? period_next : '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) count_q <= '0;
        else        count_q <= count_d;
    end

    // outputs
    assign count    = count_q;
    assign dir_down = going_down;
endmodule

// File: rtl/tmr_repeat.sv
module tmr_repeat #(
    parameter int REP_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             hw_evt,
    input  logic             reload,
    input  logic [REP_W-1:0] rep_pre,
    output logic             irq
);
    logic [REP_W-1:0] rcnt_q;
    logic             at_zero;

    assign at_zero = (rcnt_q == '0);
    assign irq     = hw_evt && !reload && at_zero;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rcnt_q <= '0;
        end else if (reload) begin
            rcnt_q <= rep_pre;
        end else if (en && hw_evt) begin
            rcnt_q <= at_zero ? rep_pre : rcnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/tmr_timebase.sv
module tmr_timebase
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PSC_W = 16,
    parameter int REP_W = 8
) (
    input  logic                                          clk,
    input  logic                                          rst_n,
    input  logic                                          cnt_en,
    input  logic [1:0]                                    mode,
    input  logic                                          wr_en,
    input  logic [1:0]                                    wr_sel,
    input  logic [((CNT_W > PSC_W) ? CNT_W : PSC_W)-1:0]  wr_data,
    input  logic                                          sw_update,
    output logic [CNT_W-1:0]                              count_value,
    output logic                                          update_evt,
    output logic                                          update_irq,
    output logic                                          dir_down
);
    localparam int WR_W = (CNT_W > PSC_W) ? CNT_W : PSC_W;

    logic [PSC_W-1:0] div_pre_q, div_act_q;
    logic [CNT_W-1:0] per_pre_q, per_act_q;
    logic [REP_W-1:0] rep_pre_q;
    logic             tick;
    logic             hw_evt;

    // preload copies
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_pre_q <= '0;
            per_pre_q <= '1;
            rep_pre_q <= '0;
        end else if (wr_en) begin
            unique case (wr_sel)
                SEL_DIV:  div_pre_q <= wr_data[PSC_W-1:0];
                SEL_PER:  per_pre_q <= wr_data[CNT_W-1:0];
                SEL_REP:  rep_pre_q <= wr_data[REP_W-1:0];
                SEL_NONE: ;
            endcase
        end
    end

    // active copies, loaded only on an update event
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_act_q <= '0;
            per_act_q <= '1;
        end else if (update_evt) begin
            div_act_q <= div_pre_q;
            per_act_q <= per_pre_q;
        end
    end

    tmr_prescaler #(.PSC_W(PSC_W)) u_psc (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (cnt_en),
        .clr     (sw_update),
        .div_act (div_act_q),
        .tick    (tick)
    );

    tmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick),
        .clr         (sw_update),
        .mode        (mode),
        .period_act  (per_act_q),
        .period_next (per_pre_q),
        .count       (count_value),
        .wrap        (hw_evt),
        .dir_down    (dir_down)
    );

    tmr_repeat #(.REP_W(REP_W)) u_rep (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (cnt_en),
        .hw_evt  (hw_evt),
        .reload  (sw_update),
        .rep_pre (rep_pre_q),
        .irq     (update_irq)
    );

    assign update_evt = hw_evt || sw_update;

    logic unused_wr;
    assign unused_wr = ^wr_data[WR_W-1:0];
endmodule

// File: rtl/tmr_timebase_chk.sv
module tmr_timebase_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cnt_en,
    input logic [1:0]       mode,
    input logic             sw_update,
    input logic [CNT_W-1:0] count_value,
    input logic             update_evt,
    input logic             update_irq,
    input logic             dir_down
);
    AST_IRQ_WITH_EVT: assert property (@(posedge clk) disable iff (!rst_n)
        update_irq |-> (update_evt && !sw_update)); // R10

    AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_en && !sw_update) |=> $stable(count_value)); // R11

    AST_NO_EVT_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_en && !sw_update) |-> !update_evt); // R11

    AST_SW_EVT: assert property (@(posedge clk) disable iff (!rst_n)
        sw_update |-> update_evt); // R9

    AST_UP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b00 && !sw_update && !update_evt) |=>
        (count_value == $past(count_value) || count_value == $past(count_value) + 1'b1)); // R4

    AST_UP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b00 && update_evt && !sw_update) |=> (count_value == '0)); // R4

    AST_DOWN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b01 && !sw_update && !update_evt) |=>
        (count_value == $past(count_value) || count_value == $past(count_value) - 1'b1)); // R5

    AST_DOWN_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b01) |-> dir_down); // R12

    AST_CTR_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        (mode[1] && update_evt && !sw_update) |=> (!mode[1] || dir_down != $past(dir_down))); // R6
endmodule

bind tmr_timebase tmr_timebase_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cnt_en      (cnt_en),
    .mode        (mode),
    .sw_update   (sw_update),
    .count_value (count_value),
    .update_evt  (update_evt),
    .update_irq  (update_irq),
    .dir_down    (dir_down)
);

// File: tb/tmr_timebase_bench.sv
module tmr_timebase_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cnt_en = 1'b0;
    logic [1:0]  mode = 2'b00;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'b00;
    logic [15:0] wr_data = '0;
    logic        sw_update = 1'b0;
    logic [15:0] count_value;
    logic        update_evt;
    logic        update_irq;
    logic        dir_down;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    tmr_timebase u_tmr_timebase (
        .clk         (clk),
        .rst_n       (rst_n),
        .cnt_en      (cnt_en),
        .mode        (mode),
        .wr_en       (wr_en),
        .wr_sel      (wr_sel),
        .wr_data     (wr_data),
        .sw_update   (sw_update),
        .count_value (count_value),
        .update_evt  (update_evt),
        .update_irq  (update_irq),
        .dir_down    (dir_down)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic write_reg(input logic [1:0] sel, input logic [15:0] val);
        wr_en = 1'b1; wr_sel = sel; wr_data = val;
        step();
        wr_en = 1'b0;
    endtask

    task automatic soft_update();
        sw_update = 1'b1;
        step();
        sw_update = 1'b0;
    endtask

    task automatic wait_evt(output int n);
        n = 0;
        do begin
            step();
            n++;
        end while (!update_evt && n < 5000);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) step();
        rst_n = 1'b1;
        step();
        check("R1 count", count_value, 0);
        check("R1 dir", dir_down, 0);
        check("R1 evt", update_evt, 0);
        check("R1 irq", update_irq, 0);
        cnt_en = 1'b1;
        repeat (3) step();
        check("R1 R3 reset divisor ticks every cycle", count_value, 3);
    endtask

    task automatic t_up();
        int n;
        mode = 2'b00;
        write_reg(2'd0, 16'd2);
        write_reg(2'd1, 16'd4);
        soft_update();
        check("R9 count after sw update", count_value, 0);
        wait_evt(n);
        check("R3 R7 first interval", n, 14);
        check("R4 top count", count_value, 4);
        wait_evt(n);
        check("R7 up interval", n, 15);
        step();
        check("R4 wrap to zero", count_value, 0);
    endtask

    task automatic t_preload();
        int n;
        write_reg(2'd0, 16'd0);
        write_reg(2'd1, 16'd9);
        write_reg(2'd3, 16'd7);
        wait_evt(n);
        check("R8 old period kept", n, 11);
        wait_evt(n);
        check("R8 R2 new period active", n, 10);
    endtask

    task automatic t_down();
        int n;
        mode = 2'b01;
        write_reg(2'd1, 16'd5);
        soft_update();
        check("R5 R9 reload on sw update", count_value, 5);
        check("R12 dir in down mode", dir_down, 1);
        wait_evt(n);
        check("R5 ticks to zero", n, 5);
        check("R5 underflow at zero", count_value, 0);
        wait_evt(n);
        check("R7 down interval", n, 6);
        step();
        check("R5 reload period", count_value, 5);
    endtask

    task automatic t_center();
        int n;
        mode = 2'b10;
        write_reg(2'd1, 16'd3);
        soft_update();
        check("R6 start count", count_value, 0);
        check("R12 rising dir", dir_down, 0);
        wait_evt(n);
        check("R6 reach top", n, 3);
        check("R6 top value", count_value, 3);
        step();
        check("R6 after top", count_value, 2);
        check("R6 R12 dir flips down", dir_down, 1);
        wait_evt(n);
        check("R6 reach bottom", n, 2);
        check("R6 bottom value", count_value, 0);
        step();
        check("R6 after bottom", count_value, 1);
        check("R6 R12 dir flips up", dir_down, 0);
        wait_evt(n);
        wait_evt(n);
        check("R7 center interval", n, 3);
    endtask

    task automatic t_repeat();
        int n;
        mode = 2'b00;
        write_reg(2'd1, 16'd1);
        write_reg(2'd2, 16'd2);
        soft_update();
        for (int k = 0; k < 6; k++) begin
            wait_evt(n);
            check("R10 irq every third event", update_irq, (k % 3 == 2) ? 1 : 0);
        end
        write_reg(2'd2, 16'd0);
    endtask

    task automatic t_hold();
        int held;
        write_reg(2'd1, 16'd9);
        soft_update();
        repeat (3) step();
        check("R11 count before hold", count_value, 3);
        cnt_en = 1'b0;
        held = 1;
        for (int k = 0; k < 10; k++) begin
            step();
            if (count_value != 16'd3 || update_evt) held = 0;
        end
        check("R11 held while disabled", held, 1);
        cnt_en = 1'b1;
        step();
        check("R11 resumes", count_value, 4);
    endtask

    task automatic t_sw();
        int n;
        write_reg(2'd1, 16'd2);
        sw_update = 1'b1;
        #1;
        check("R9 event in request cycle", update_evt, 1);
        step();
        sw_update = 1'b0;
        check("R9 count cleared", count_value, 0);
        wait_evt(n);
        check("R9 new period at once", n, 2);
    endtask

    initial begin
        t_reset();
        t_up();
        t_preload();
        t_down();
        t_center();
        t_repeat();
        t_hold();
        t_sw();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule